// File: doc/BRIEF.md
# Monochrome Colour Expander

This block turns a packed one-bit-per-pixel source image into 8-bit colour pixels for a drawing engine. Each source bit chooses between two colours captured when an operation is launched: a one picks the foreground colour and a zero picks the background colour. The operation covers a rectangle of `row_count` rows, each `row_width` pixels wide.

A control word shapes each row. A discard count drops leading source bits at the start of every row. The left and right clip counts mask pixels at the row edges by lowering their write-enable. An alignment code says where the next row's source data starts, so padded source rows can be walked without software help. With the transparent-background option set, pixels from zero bits are still emitted but carry write-enable low. Addresses and raster operations belong to the surrounding engine.

Source words arrive on a valid/ready stream. A word is held while `src_valid` is high and `src_ready` is low, and it is taken on the edge where both are high. Pixels leave on a valid/ready stream. While `pix_valid` is high and `pix_ready` is low, `pix_data` and `pix_we` stay frozen, and the expander stalls without losing a bit. The block always starts an operation on a fresh source word. Unused bits left in the last word are dropped.

Top module: `mono_expand`

## Requirements
- R1: After reset, and whenever `busy` is low, `pix_valid` and `src_ready` are low. `busy` rises on the cycle after a `start` that is sampled while idle. It stays high until the last pixel has been accepted.
- R2: Source bits are consumed starting with bits 7:0 of each word, then bits 15:8, and so on. Within each byte the most significant bit comes first. A one bit yields `fg_color[7:0]` and a zero bit yields `bg_color[7:0]`. Colour bits 31:8 have no effect.
- R3: `ctrl_word[5:0]` is the left clip count L. Pixel columns 0 to L-1 of every row carry `pix_we` low.
- R4: `ctrl_word[13:8]` is the right clip count R. Pixel columns c with c+R >= `row_width` carry `pix_we` low.
- R5: `ctrl_word[21:16]` is the discard count D. At the start of every row, the next D source bits are skipped before the first pixel bit. This holds even when the skip crosses a word boundary.
- R6: `ctrl_word[26:24]` is the alignment code: 1 = 1 bit, 2 = 8 bits, 3 = 16 bits, 4 = 32 bits, 5 = 64 bits. Codes 0, 6 and 7 mean 8 bits. After the final pixel of a row, the bit position moves up to the next multiple of that size, measured from the operation's first bit. If it is already a multiple, it stays.
- R7: With `bg_transparent` set, every pixel from a zero bit has `pix_we` low. Without it, zero-bit pixels are written unless clipped.
- R8: An operation emits exactly `row_width` × `row_count` pixels, in row order and left to right within each row. It accepts exactly as many source words as hold at least one pixel bit.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_data` and `pix_we` keep their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse. Configuration is captured when this is sampled while idle |
| ctrl_word | input | 32 | Clip, discard and alignment fields |
| fg_color | input | 32 | Foreground colour. Only bits 7:0 are used |
| bg_color | input | 32 | Background colour. Only bits 7:0 are used |
| bg_transparent | input | 1 | Zero bits produce pixels with write-enable low |
| row_width | input | 16 | Pixels per row, at least 1 |
| row_count | input | 16 | Rows per operation, at least 1 |
| busy | output | 1 | Operation in progress or a pixel still pending |
| src_valid | input | 1 | Source word offered |
| src_ready | output | 1 | Expander takes the offered word |
| src_data | input | 64 | Source word, byte 0 first, MSB first within each byte |
| pix_valid | output | 1 | Pixel offered |
| pix_ready | input | 1 | Consumer takes the pixel |
| pix_data | output | 8 | Pixel colour |
| pix_we | output | 1 | Write-enable for this pixel |

## Verification
The assertions assume that `row_width` and `row_count` are non-zero at launch. They also assume that `start` is raised only while `busy` is low, and that a source word, once offered, stays valid until it is taken. The bench launches each operation only after `busy` has fallen and always uses non-zero dimensions. Its source driver holds `src_valid` and `src_data` on any word that has not been accepted, even when a gap pattern is active. The bench also supplies exactly the number of source words its own model predicts, so any over-fetch shows up as a stall and a miscount.

// File: rtl/mce_pkg.sv
package mce_pkg;

  localparam int MCE_FIELD_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SKIP,
    ST_PIX,
    ST_ALIGN
  } walk_st_t;

  typedef struct packed {
    logic [MCE_FIELD_W-1:0] lclip;
    logic [MCE_FIELD_W-1:0] rclip;
    logic [MCE_FIELD_W-1:0] disc;
    logic [2:0]             alog;   // log2 of the row alignment in bits
  } mce_cfg_t;

  function automatic logic [2:0] align_log2(input logic [2:0] code);
    case (code)
      3'd1:    align_log2 = 3'd0;
      3'd2:    align_log2 = 3'd3;
      3'd3:    align_log2 = 3'd4;
      3'd4:    align_log2 = 3'd5;
      3'd5:    align_log2 = 3'd6;
      default: align_log2 = 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/mce_cfg_decode.sv
module mce_cfg_decode
  import mce_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  output mce_cfg_t          cfg
);

  // Field positions are fixed by the software-visible control word layout.
  always_comb begin
    cfg.lclip = ctrl_word[5:0];
    cfg.rclip = ctrl_word[13:8];
    cfg.disc  = ctrl_word[21:16];
    cfg.alog  = align_log2(ctrl_word[26:24]);
  end

endmodule

// File: rtl/mce_bit_walker.sv
module mce_bit_walker
  import mce_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  mce_cfg_t          cfg,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  rows,
  input  logic              src_valid,
  input  logic [WORD_W-1:0] src_data,
  output logic              src_ready,
  input  logic              out_free,
  output logic              emit,
  output logic              emit_bit,
  output logic              emit_vis,
  output logic              active
);

  localparam int PTR_W = $clog2(WORD_W);
  localparam int SUM_W = PTR_W + 1;

  walk_st_t          state_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [WORD_W-1:0] hold_q;
  logic              hold_vld_q;
  logic [DIM_W-1:0]  col_q;
  logic [DIM_W-1:0]  row_q;
  logic [DIM_W-1:0]  width_q;
  logic [DIM_W-1:0]  rows_q;
  mce_cfg_t          cfg_q;

  logic [SUM_W-1:0]  skip_sum;
  logic [SUM_W-1:0]  amask;
  logic [SUM_W-1:0]  aligned;
  logic [PTR_W-1:0]  bit_idx;
  logic              last_col;

  always_comb begin
    skip_sum = SUM_W'(ptr_q) + SUM_W'(cfg_q.disc);
    amask    = (SUM_W'(1) << cfg_q.alog) - SUM_W'(1);
    aligned  = (SUM_W'(ptr_q) + amask) & ~amask;
    // byte lane from the upper pointer bits, MSB first inside the byte
    bit_idx  = {ptr_q[PTR_W-1:3], ~ptr_q[2:0]};
    last_col = (col_q == width_q - DIM_W'(1));
  end

  assign active    = (state_q != ST_IDLE);
  assign src_ready = (state_q == ST_PIX) && !hold_vld_q;
  assign emit      = (state_q == ST_PIX) && hold_vld_q && out_free;
  assign emit_bit  = hold_q[bit_idx];
  assign emit_vis  = ({1'b0, col_q} >= (DIM_W+1)'(cfg_q.lclip)) &&
                     (({1'b0, col_q} + (DIM_W+1)'(cfg_q.rclip)) < {1'b0, width_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      col_q      <= '0;
      row_q      <= '0;
      width_q    <= '0;
      rows_q     <= '0;
      cfg_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          hold_vld_q <= 1'b0;
          if (start_go) begin
            cfg_q   <= cfg;
            width_q <= width;
            rows_q  <= rows;
            ptr_q   <= '0;
            col_q   <= '0;
            row_q   <= '0;
            state_q <= ST_SKIP;
          end
        end
        ST_SKIP: begin
          if (skip_sum[PTR_W]) hold_vld_q <= 1'b0;
          ptr_q   <= skip_sum[PTR_W-1:0];
          state_q <= ST_PIX;
        end
        ST_PIX: begin
          if (!hold_vld_q) begin
            if (src_valid) begin
              hold_q     <= src_data;
              hold_vld_q <= 1'b1;
            end
          end else if (out_free) begin
            ptr_q <= ptr_q + PTR_W'(1);
            if (&ptr_q) hold_vld_q <= 1'b0;
            if (last_col) begin
              col_q   <= '0;
              state_q <= ST_ALIGN;
            end else begin
              col_q <= col_q + DIM_W'(1);
            end
          end
        end
        ST_ALIGN: begin
          if (aligned[PTR_W]) hold_vld_q <= 1'b0;
          ptr_q <= aligned[PTR_W-1:0];
          if (row_q == rows_q - DIM_W'(1)) begin
            state_q <= ST_IDLE;
          end else begin
            row_q   <= row_q + DIM_W'(1);
            state_q <= ST_SKIP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PIX) |-> (col_q < width_q));

  // R6
  align_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ALIGN) |=> ((SUM_W'(ptr_q) & amask) == '0));

  // R8
  load_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready) |=> hold_vld_q);

endmodule

// File: rtl/mce_pixel_out.sv
module mce_pixel_out #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_go,
  input  logic [PIX_W-1:0] fg_in,
  input  logic [PIX_W-1:0] bg_in,
  input  logic             transp_in,
  input  logic             emit,
  input  logic             emit_bit,
  input  logic             emit_vis,
  input  logic             pix_ready,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_data,
  output logic             pix_we,
  output logic             out_free
);

  logic [PIX_W-1:0] fg_q;
  logic [PIX_W-1:0] bg_q;
  logic             transp_q;

  assign out_free = !pix_valid || pix_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fg_q      <= '0;
      bg_q      <= '0;
      transp_q  <= 1'b0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_we    <= 1'b0;
    end else begin
      if (start_go) begin
        fg_q     <= fg_in;
        bg_q     <= bg_in;
        transp_q <= transp_in;
      end
      if (emit) begin
        pix_valid <= 1'b1;
        pix_data  <= emit_bit ? fg_q : bg_q;
        pix_we    <= emit_vis && (emit_bit || !transp_q);
      end else if (pix_ready) begin
        pix_valid <= 1'b0;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) && $stable(pix_we)));

  // R7
  transp_fg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_we && transp_q) |-> (pix_data == fg_q));

endmodule

// File: rtl/mono_expand.sv
module mono_expand
  import mce_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int PIX_W   = 8,
  parameter int DIM_W   = 16,
  parameter int CTRL_W  = 32,
  parameter int COLOR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CTRL_W-1:0]  ctrl_word,
  input  logic [COLOR_W-1:0] fg_color,
  input  logic [COLOR_W-1:0] bg_color,
  input  logic               bg_transparent,
  input  logic [DIM_W-1:0]   row_width,
  input  logic [DIM_W-1:0]   row_count,
  output logic               busy,
  input  logic               src_valid,
  output logic               src_ready,
  input  logic [WORD_W-1:0]  src_data,
  output logic               pix_valid,
  input  logic               pix_ready,
  output logic [PIX_W-1:0]   pix_data,
  output logic               pix_we
);

  mce_cfg_t cfg;
  logic     start_go;
  logic     walk_active;
  logic     out_free;
  logic     emit;
  logic     emit_bit;
  logic     emit_vis;
  logic     unused_bits;

  assign unused_bits = ^{fg_color[COLOR_W-1:PIX_W], bg_color[COLOR_W-1:PIX_W],
                         ctrl_word[CTRL_W-1:27], ctrl_word[23:22],
                         ctrl_word[15:14], ctrl_word[7:6]};

  assign busy     = walk_active || pix_valid;
  assign start_go = start && !busy;

  mce_cfg_decode #(.CTRL_W(CTRL_W)) u_decode (
    .ctrl_word (ctrl_word),
    .cfg       (cfg)
  );

  mce_bit_walker #(.WORD_W(WORD_W), .DIM_W(DIM_W)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_go  (start_go),
    .cfg       (cfg),
    .width     (row_width),
    .rows      (row_count),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_ready (src_ready),
    .out_free  (out_free),
    .emit      (emit),
    .emit_bit  (emit_bit),
    .emit_vis  (emit_vis),
    .active    (walk_active)
  );

  mce_pixel_out #(.PIX_W(PIX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_go  (start_go),
    .fg_in     (fg_color[PIX_W-1:0]),
    .bg_in     (bg_color[PIX_W-1:0]),
    .transp_in (bg_transparent),
    .emit      (emit),
    .emit_bit  (emit_bit),
    .emit_vis  (emit_vis),
    .pix_ready (pix_ready),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_we    (pix_we),
    .out_free  (out_free)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pix_valid && !src_ready));

endmodule

// File: tb/mono_expand_bench.sv
`timescale 1ns/1ps
module mono_expand_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [31:0] fg_color = '0;
  logic [31:0] bg_color = '0;
  logic        bg_transparent = 1'b0;
  logic [15:0] row_width = '0;
  logic [15:0] row_count = '0;
  logic        busy;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [63:0] src_data = '0;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic [7:0]  pix_data;
  logic        pix_we;

  int vectors = 0;
  int fails = 0;

  logic [63:0] words [64];
  logic [7:0]  exp_d [4096];
  logic        exp_we [4096];

  always #2 clk = ~clk;

  mono_expand u_mono_expand (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
    .fg_color(fg_color), .bg_color(bg_color), .bg_transparent(bg_transparent),
    .row_width(row_width), .row_count(row_count), .busy(busy),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_we(pix_we)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] gen_word(input int s, input int i);
    logic [31:0] a, b;
    a = 32'h9e3779b9 * 32'(s + 1) + 32'h7f4a7c15 * 32'(i + 1);
    b = {a[15:0], a[31:16]} ^ (32'hc2b2ae35 * 32'(i + 3));
    return {a ^ (a >> 13), b};
  endfunction

  function automatic logic src_bit(input int pos);
    int k;
    k = pos % 64;
    return words[pos / 64][(k / 8) * 8 + 7 - (k % 8)];
  endfunction

  function automatic int align_size(input int code);
    case (code)
      1: return 1;
      2: return 8;
      3: return 16;
      4: return 32;
      5: return 64;
      default: return 8;
    endcase
  endfunction

  task automatic run_op(input string req, input int w, input int r, input int lc,
                        input int rc, input int dc, input int code, input bit tr,
                        input int seed, input bit bp);
    int pos, n, last, need, asz, got, sidx, cyc;
    bit pend_src, held, prev_stall, b;
    logic [7:0] prev_d;
    logic prev_we;
    logic [7:0] fgc, bgc;
    fgc = 8'(seed * 37 + 11);
    bgc = ~fgc ^ 8'h24;
    for (int i = 0; i < 64; i++) words[i] = gen_word(seed, i);
    asz = align_size(code);
    pos = 0; n = 0; last = 0;
    for (int row = 0; row < r; row++) begin
      pos += dc;
      for (int c = 0; c < w; c++) begin
        b = src_bit(pos);
        exp_d[n]  = b ? fgc : bgc;
        exp_we[n] = (c >= lc) && (c + rc < w) && (b || !tr);
        last = pos; pos++; n++;
      end
      pos = ((pos + asz - 1) / asz) * asz;
    end
    need = last / 64 + 1;

    @(negedge clk);
    ctrl_word = (32'(code) << 24) | (32'(dc) << 16) | (32'(rc) << 8) | 32'(lc);
    fg_color = {24'hdead5a, fgc};
    bg_color = {24'h7c3e91, bgc};
    bg_transparent = tr;
    row_width = 16'(w);
    row_count = 16'(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", {req, " busy after start"}, 32'(busy), 1);

    got = 0; sidx = 0; cyc = 0; pend_src = 0; prev_stall = 0;
    prev_d = '0; prev_we = 1'b0;
    while (!(got == n && !busy) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      held = src_valid && !pend_src;
      if (pend_src) sidx++;
      if (!held) begin
        src_valid = (sidx < need) && (!bp || (cyc % 5) != 2);
        src_data  = words[sidx % 64];
      end
      pend_src = src_valid && src_ready;
      if (prev_stall)
        chk(pix_valid && pix_data == prev_d && pix_we == prev_we, "R9",
            {req, " stalled pixel changed"}, {23'd0, pix_valid, pix_we, pix_data},
            {23'd0, 1'b1, prev_we, prev_d});
      pix_ready = !bp || (cyc % 3) != 0;
      if (pix_valid && pix_ready) begin
        if (got < n)
          chk(pix_data == exp_d[got] && pix_we == exp_we[got], req,
              $sformatf("pixel %0d data/we", got), {23'd0, pix_we, pix_data},
              {23'd0, exp_we[got], exp_d[got]});
        else
          chk(1'b0, "R8", {req, " extra pixel"}, 32'(got), 32'(n));
        got++;
      end
      prev_stall = pix_valid && !pix_ready;
      prev_d = pix_data; prev_we = pix_we;
    end
    if (pend_src) sidx++;
    src_valid = 1'b0;
    pix_ready = 1'b0;
    chk(cyc < 20000, "R8", {req, " operation completes"}, 32'(cyc), 20000);
    chk(got == n, "R8", {req, " pixel count"}, 32'(got), 32'(n));
    chk(sidx == need, "R8", {req, " source words taken"}, 32'(sidx), 32'(need));
    chk(!pix_valid && !src_ready, "R1", {req, " quiet when idle"},
        {30'd0, pix_valid, src_ready}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !pix_valid && !src_ready, "R1", "reset outputs",
        {29'd0, busy, pix_valid, src_ready}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !pix_valid && !src_ready, "R1", "after reset release",
        {29'd0, busy, pix_valid, src_ready}, 0);
  endtask

  task automatic t_basic;        // R2, code 0 counts as byte (R6)
    run_op("R2", 20, 2, 0, 0, 0, 0, 1'b0, 1, 1'b0);
  endtask

  task automatic t_clip;         // R3 and R4
    run_op("R3", 24, 3, 3, 5, 0, 2, 1'b0, 2, 1'b0);
    run_op("R4", 70, 2, 10, 60, 0, 2, 1'b0, 3, 1'b1);
  endtask

  task automatic t_discard;      // R5 with qword rows and a word-crossing skip
    run_op("R5", 30, 3, 0, 0, 13, 5, 1'b0, 4, 1'b0);
    run_op("R5", 30, 3, 1, 1, 50, 1, 1'b0, 5, 1'b1);
  endtask

  task automatic t_align;        // R6 bit, word, dword, odd codes
    run_op("R6", 7, 4, 0, 0, 2, 1, 1'b0, 6, 1'b0);
    run_op("R6", 9, 3, 0, 0, 0, 3, 1'b0, 7, 1'b0);
    run_op("R6", 40, 2, 0, 0, 5, 4, 1'b0, 8, 1'b1);
    run_op("R6", 5, 3, 0, 0, 0, 7, 1'b0, 9, 1'b0);
    run_op("R6", 11, 2, 0, 0, 3, 6, 1'b0, 10, 1'b0);
  endtask

  task automatic t_transp;       // R7
    run_op("R7", 9, 3, 0, 0, 0, 3, 1'b1, 11, 1'b0);
    run_op("R7", 40, 2, 2, 2, 5, 4, 1'b1, 12, 1'b1);
  endtask

  task automatic t_stream;       // R8 and R9 with long rows under back-pressure
    run_op("R8", 200, 4, 0, 0, 0, 5, 1'b0, 13, 1'b1);
    run_op("R9", 63, 3, 0, 0, 1, 2, 1'b1, 14, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_clip();
    t_discard();
    t_align();
    t_transp();
    t_stream();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule